// File: doc/BRIEF.md
# Multi-Class Linear Score Engine

This block scores a flattened motion-history frame against several one-versus-all linear classifiers at once. Pixels come in one at a time in raster scan order with a valid strobe. For each accepted pixel the engine fetches one signed fixed-point weight per class from an external read-only weight store, forms the products and adds them into one wide signed accumulator per class. After the last pixel it adds each class's bias, scans the finished scores and reports the index of the largest one together with a one-cycle completion pulse.

A controller with five named states sequences the work. IDLE waits for `start`. ACCUM accepts pixels, and its transition ACCUM to BIAS is taken on the edge that accepts the final pixel. BIAS lasts one cycle, adds the bias terms and always moves to SCAN. SCAN visits one class per cycle and moves to FINISH after the last class. FINISH raises `done` for one cycle and returns to IDLE. `start` forces a move to ACCUM from any state, clearing the accumulators and the pixel index. The weight address output is combinational with respect to the read: the weight store must return the word for `wgt_addr` in the same cycle.

Top module: `lincls_scorer`

## Requirements
- R1: Each weight is a 16-bit two's complement value with 8 fraction bits. Class c's weight is `wgt_data[c*16 +: 16]`. Each pixel is an unsigned 8-bit integer, zero-extended before it is multiplied, so a pixel of 255 contributes +255 times the weight.
- R2: Each class score is a 32-bit signed value with 8 fraction bits. Every addition into it, from the multiply step or from the bias step, clamps to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R3: The k-th accepted pixel (k counting from 0 after `start`) is multiplied with the weight word at address k, and `wgt_addr` equals k while that pixel is awaited. Cycles with `pix_valid` low change neither the scores nor `wgt_addr`. Pixels offered outside the accumulate phase are ignored.
- R4: After the last of NUM_FEAT pixels, each class's bias (`bias_data[c*32 +: 32]`, same 24.8 format as the score) is added once to its score. The final scores appear on `scores[c*32 +: 32]` and hold until the next `start`.
- R5: `label` is the index of the class with the largest signed final score. When scores are equal, the lowest index wins.
- R6: `start` clears all scores to zero and restarts at pixel 0 from any state, including in the middle of a frame.
- R7: `done` is high for exactly one cycle. That cycle is the one after the (NUM_CLASS+1)-th rising edge following the edge that accepted the last pixel. `label` is valid from that cycle and holds until the next frame completes.
- R8: After reset, `done` is 0 and `label`, `wgt_addr` and all scores are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new frame; clears scores |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W (8) | Unsigned pixel value |
| wgt_addr | output | FEAT_AW (4) | Feature index awaiting its pixel |
| wgt_data | input | NUM_CLASS*WGT_W (48) | Weights of all classes at `wgt_addr`, same cycle |
| bias_data | input | NUM_CLASS*ACC_W (96) | Per-class bias, 24.8 signed |
| scores | output | NUM_CLASS*ACC_W (96) | Per-class accumulated scores |
| label | output | CLS_W (2) | Winning class index |
| done | output | 1 | One-cycle completion pulse |

## Verification
A pixel's products show up on `scores` right after the edge that accepts it. The bias term lands one edge after the last pixel, and `done` with its `label` follows NUM_CLASS+1 edges after that last pixel. The bench model keeps the same edge count. It advances at each rising edge and compares at the falling edge: running scores during accumulation, `done` in every cycle, and held scores and label once the frame is complete. Scores are not compared during the bias and scan cycles, because the exact cycle of the bias step is internal there and only the completed values are specified.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_BIAS,
        ST_SCAN,
        ST_FINISH
    } lcs_state_e;

    // Index width that stays at least one bit for a count of one.
    function automatic int lcs_idx_w(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
    import lcs_pkg::*;
#(
    parameter int NUM_FEAT  = 16,
    parameter int NUM_CLASS = 3,
    parameter int FEAT_AW   = lcs_idx_w(NUM_FEAT),
    parameter int CLS_W     = lcs_idx_w(NUM_CLASS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               pix_valid,
    output logic               clr,
    output logic               mac_en,
    output logic               bias_en,
    output logic               step,
    output logic               first,
    output logic [FEAT_AW-1:0] feat_idx,
    output logic [CLS_W-1:0]   scan_idx,
    output logic               done
);

    localparam logic [FEAT_AW-1:0] LAST_FEAT = FEAT_AW'(NUM_FEAT - 1);
    localparam logic [CLS_W-1:0]   LAST_CLS  = CLS_W'(NUM_CLASS - 1);

    lcs_state_e state, state_nx;
    logic last_feat, last_cls;

    assign last_feat = (feat_idx == LAST_FEAT);
    assign last_cls  = (scan_idx == LAST_CLS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_ACCUM;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_ACCUM:  if (pix_valid && last_feat) state_nx = ST_BIAS;
                ST_BIAS:   state_nx = ST_SCAN;
                ST_SCAN:   if (last_cls) state_nx = ST_FINISH;
                ST_FINISH: state_nx = ST_IDLE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Pixel and class indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feat_idx <= '0;
            scan_idx <= '0;
        end else begin
            if (start) begin
                feat_idx <= '0;
            end else if (state == ST_ACCUM && pix_valid) begin
                feat_idx <= last_feat ? '0 : feat_idx + 1'b1;
            end

            if (start || state == ST_BIAS) begin
                scan_idx <= '0;
            end else if (state == ST_SCAN) begin
                scan_idx <= last_cls ? '0 : scan_idx + 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        clr     = start;
        mac_en  = 1'b0;
        bias_en = 1'b0;
        step    = 1'b0;
        done    = 1'b0;
        first   = (scan_idx == '0);
        unique case (state)
            ST_IDLE:   ;
            ST_ACCUM:  mac_en  = pix_valid && !start;
            ST_BIAS:   bias_en = !start;
            ST_SCAN:   step    = !start;
            ST_FINISH: done    = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/lcs_mac_lane.sv
module lcs_mac_lane #(
    parameter int PIX_W = 8,
    parameter int WGT_W = 16,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    mac_en,
    input  logic                    bias_en,
    input  logic [PIX_W-1:0]        pix,
    input  logic signed [WGT_W-1:0] wgt,
    input  logic signed [ACC_W-1:0] bias,
    output logic signed [ACC_W-1:0] acc
);

    localparam int PROD_W = PIX_W + 1 + WGT_W;
    localparam int EXT_W  = ACC_W + 2;
    localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((longint'(1) <<< (ACC_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] SAT_LO = -SAT_HI - EXT_W'(1);

    logic signed [PROD_W-1:0] prod;
    logic signed [EXT_W-1:0]  addend;
    logic signed [EXT_W-1:0]  sum;
    logic signed [ACC_W-1:0]  clamped;

    // Pixel is unsigned: a zero sign bit is prepended before the signed multiply.
    assign prod = $signed({1'b0, pix}) * wgt;

    always_comb begin
        addend = bias_en ? EXT_W'(bias) : EXT_W'(prod);
        sum    = EXT_W'(acc) + addend;
        if (sum > SAT_HI) begin
            clamped = ACC_W'(SAT_HI);
        end else if (sum < SAT_LO) begin
            clamped = ACC_W'(SAT_LO);
        end else begin
            clamped = ACC_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (mac_en || bias_en) begin
            acc <= clamped;
        end
    end

endmodule

// File: rtl/lcs_argmax.sv
module lcs_argmax #(
    parameter int NUM_CLASS = 3,
    parameter int ACC_W     = 32,
    parameter int CLS_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic                       first,
    input  logic [CLS_W-1:0]           scan_idx,
    input  logic [NUM_CLASS*ACC_W-1:0] scores,
    output logic [CLS_W-1:0]           label
);

    localparam int SLOTS = 1 << CLS_W;

    logic signed [ACC_W-1:0] slot_v [SLOTS];
    logic signed [ACC_W-1:0] cand;
    logic signed [ACC_W-1:0] best_val;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_CLASS) begin : g_real
            assign slot_v[g] = scores[g*ACC_W +: ACC_W];
        end else begin : g_pad
            assign slot_v[g] = '0;
        end
    end

    assign cand = slot_v[scan_idx];

    // Strict comparison keeps the earlier (lower) index on equal scores.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_val <= '0;
            label    <= '0;
        end else if (step && (first || cand > best_val)) begin
            best_val <= cand;
            label    <= scan_idx;
        end
    end

endmodule

// File: rtl/lincls_scorer.sv
module lincls_scorer
    import lcs_pkg::*;
#(
    parameter int NUM_CLASS = 3,
    parameter int NUM_FEAT  = 16,
    parameter int PIX_W     = 8,
    parameter int WGT_W     = 16,
    parameter int ACC_W     = 32,
    localparam int FEAT_AW  = lcs_idx_w(NUM_FEAT),
    localparam int CLS_W    = lcs_idx_w(NUM_CLASS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       pix_valid,
    input  logic [PIX_W-1:0]           pix_data,
    output logic [FEAT_AW-1:0]         wgt_addr,
    input  logic [NUM_CLASS*WGT_W-1:0] wgt_data,
    input  logic [NUM_CLASS*ACC_W-1:0] bias_data,
    output logic [NUM_CLASS*ACC_W-1:0] scores,
    output logic [CLS_W-1:0]           label,
    output logic                       done
);

    logic             clr, mac_en, bias_en, step, first;
    logic [CLS_W-1:0] scan_idx;

    lcs_ctrl #(
        .NUM_FEAT (NUM_FEAT),
        .NUM_CLASS(NUM_CLASS),
        .FEAT_AW  (FEAT_AW),
        .CLS_W    (CLS_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pix_valid(pix_valid),
        .clr      (clr),
        .mac_en   (mac_en),
        .bias_en  (bias_en),
        .step     (step),
        .first    (first),
        .feat_idx (wgt_addr),
        .scan_idx (scan_idx),
        .done     (done)
    );

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_lane
        lcs_mac_lane #(
            .PIX_W(PIX_W),
            .WGT_W(WGT_W),
            .ACC_W(ACC_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .mac_en (mac_en),
            .bias_en(bias_en),
            .pix    (pix_data),
            .wgt    (wgt_data[c*WGT_W +: WGT_W]),
            .bias   (bias_data[c*ACC_W +: ACC_W]),
            .acc    (scores[c*ACC_W +: ACC_W])
        );
    end

    lcs_argmax #(
        .NUM_CLASS(NUM_CLASS),
        .ACC_W    (ACC_W),
        .CLS_W    (CLS_W)
    ) u_argmax (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .first   (first),
        .scan_idx(scan_idx),
        .scores  (scores),
        .label   (label)
    );

endmodule

// File: rtl/lincls_scorer_chk.sv
module lincls_scorer_chk #(
    parameter int NUM_CLASS = 3,
    parameter int NUM_FEAT  = 16,
    parameter int ACC_W     = 32,
    parameter int FEAT_AW   = 4,
    parameter int CLS_W     = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       pix_valid,
    input logic [FEAT_AW-1:0]         wgt_addr,
    input logic [NUM_CLASS*ACC_W-1:0] scores,
    input logic [CLS_W-1:0]           label,
    input logic                       done
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_LABEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(label)); // R7

    AST_LABEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(label) < NUM_CLASS); // R5

    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (scores == '0)); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !start) |=> $stable(wgt_addr)); // R3

    AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wgt_addr) < NUM_FEAT); // R3

endmodule

bind lincls_scorer lincls_scorer_chk #(
    .NUM_CLASS(NUM_CLASS),
    .NUM_FEAT (NUM_FEAT),
    .ACC_W    (ACC_W),
    .FEAT_AW  (FEAT_AW),
    .CLS_W    (CLS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pix_valid(pix_valid),
    .wgt_addr (wgt_addr),
    .scores   (scores),
    .label    (label),
    .done     (done)
);

// File: tb/lincls_scorer_test.sv
module lincls_scorer_test;

    localparam int NC = 3;
    localparam int NF = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_data = '0;
    logic [3:0]    wgt_addr;
    logic [NC*16-1:0] wgt_data;
    logic [NC*32-1:0] bias_data = '0;
    logic [NC*32-1:0] scores;
    logic [1:0]    label;
    logic          done;

    int n_checks = 0;
    int n_fails  = 0;
    int wsel     = 0;
    int cycles   = 0;

    always #2 clk = ~clk; // 250 MHz

    lincls_scorer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
        .pix_data(pix_data), .wgt_addr(wgt_addr), .wgt_data(wgt_data),
        .bias_data(bias_data), .scores(scores), .label(label), .done(done)
    );

    function automatic logic signed [15:0] wrom(input int c, input int a, input int mode);
        if (mode == 1) return 16'(((a * 13) % 50) - 10);
        if (mode == 2) return (c == 0) ? 16'sh7FFF : (c == 1) ? 16'sh8000 : 16'sh0000;
        return 16'((((c * 53) + (a * 29) + 7) % 200 - 100) * 37);
    endfunction

    function automatic logic [7:0] pixgen(input int k, input int seed);
        if (seed == 0) return 8'd0;
        if (seed == 1) return 8'd255;
        return 8'(((k * seed * 7) + seed) % 256);
    endfunction

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    always_comb begin
        for (int c = 0; c < NC; c++) wgt_data[c*16 +: 16] = wrom(c, int'(wgt_addr), wsel);
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint score_of(input int c);
        return longint'($signed(scores[c*32 +: 32]));
    endfunction

    // Behavioural reference: phase 0 = after reset, 1 = collecting, 2 = finishing, 3 = complete
    int     phase = 0;
    int     cnt = 0;
    int     cd = 0;
    bit     exp_done = 0;
    int     exp_label = 0;
    longint m_acc [NC];

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; cnt = 0; cd = 0; exp_done = 0; exp_label = 0;
            for (int c = 0; c < NC; c++) m_acc[c] = 0;
        end else if (start) begin
            phase = 1; cnt = 0; exp_done = 0;
            for (int c = 0; c < NC; c++) m_acc[c] = 0;
        end else begin
            exp_done = 0;
            if (phase == 1 && pix_valid) begin
                for (int c = 0; c < NC; c++)
                    m_acc[c] = sat32(m_acc[c] + longint'(pix_data) * longint'(wrom(c, cnt, wsel)));
                if (cnt == NF - 1) begin
                    phase = 2; cd = NC + 1; cnt = 0;
                    for (int c = 0; c < NC; c++)
                        m_acc[c] = sat32(m_acc[c] + longint'($signed(bias_data[c*32 +: 32])));
                    exp_label = 0;
                    for (int c = 1; c < NC; c++) if (m_acc[c] > m_acc[exp_label]) exp_label = c;
                end else begin
                    cnt++;
                end
            end else if (phase == 2) begin
                cd--;
                if (cd == 0) begin phase = 3; exp_done = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 done", longint'(done), longint'(exp_done));
            if (phase == 0) begin
                chk("R8 label", longint'(label), 0);
                chk("R8 wgt_addr", longint'(wgt_addr), 0);
                for (int c = 0; c < NC; c++) chk("R8 score", score_of(c), 0);
            end else if (phase == 1) begin
                chk("R3 wgt_addr", longint'(wgt_addr), longint'(cnt));
                for (int c = 0; c < NC; c++) chk("R3 running score", score_of(c), m_acc[c]);
            end else if (phase == 3) begin
                chk("R5 label", longint'(label), longint'(exp_label));
                for (int c = 0; c < NC; c++) chk("R4 final score", score_of(c), m_acc[c]);
            end
        end
    end

    task automatic set_bias(input int b0, input int b1, input int b2);
        bias_data = {32'(b2), 32'(b1), 32'(b0)};
    endtask

    task automatic frame(input int seed, input bit gaps, input bit junk);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < NF; k++) begin
            if (gaps && (k % 3 == 1)) begin
                pix_valid = 1'b0; pix_data = 8'h5A;
                repeat (2) @(negedge clk);
            end
            pix_valid = 1'b1; pix_data = pixgen(k, seed);
            @(negedge clk);
        end
        pix_valid = junk; pix_data = 8'hAA; // R3: ignored outside accumulation
        repeat (NC + 6) @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset values before release
        chk("R8 done", longint'(done), 0);
        chk("R8 label", longint'(label), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R3 / R4 / R5: general weights, several pixel patterns
        wsel = 0; set_bias(0, 0, 0);
        frame(3, 0, 0);
        set_bias(1000, -2000, 512);
        frame(5, 1, 1);
        frame(11, 0, 1);

        // R5: all scores equal -> lowest index
        wsel = 1; set_bias(0, 0, 0);
        frame(9, 0, 0);
        chk("R5 tie all", longint'(label), 0);
        // R5: classes 1 and 2 tie on top
        set_bias(-1, 0, 0);
        frame(9, 1, 0);
        chk("R5 tie upper", longint'(label), 1);

        // R4 / R5: zero pixels, bias alone decides
        wsel = 0; set_bias(-500, -20, -300);
        frame(0, 0, 0);
        chk("R4 bias only", score_of(1), -20);
        chk("R5 bias winner", longint'(label), 1);

        // R1: pixel 255 zero-extended, extreme weights
        wsel = 2; set_bias(0, 0, 0);
        frame(1, 0, 0);
        chk("R1 zero-extend pos", score_of(0), longint'(NF) * 255 * 32767);
        chk("R1 zero-extend neg", score_of(1), -longint'(NF) * 255 * 32768);

        // R2: saturation in both directions through the bias add
        set_bias(32'h7FFF0000, 32'h80100000, 0);
        frame(1, 0, 0);
        chk("R2 sat high", score_of(0), 64'sd2147483647);
        chk("R2 sat low", score_of(1), -64'sd2147483648);

        // R6: restart in the middle of a frame
        wsel = 0; set_bias(7, 8, 9);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            pix_valid = 1'b1; pix_data = pixgen(k, 13);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < NC; c++) chk("R6 cleared", score_of(c), 0);
        chk("R6 index restart", longint'(wgt_addr), 0);
        for (int k = 0; k < NF; k++) begin
            pix_valid = 1'b1; pix_data = pixgen(k, 17);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (NC + 6) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule